// File: doc/BRIEF.md
# Age-Ordered Multi-Slot Stage Register

This block sits between two pipeline stages. It replaces a single pipeline register with a small pool of instruction slots. Each slot holds an occupied bit, an instruction payload and a 32-bit age. A larger age means a younger instruction.

The producer sees a ready flag whenever any slot is empty. When the flag is high, it may push one instruction into the pool. The consumer sees a valid flag whenever any slot is occupied, and the pop port always presents the oldest entry. Asserting the pop request removes that entry at the next clock edge.

The pool is not a FIFO. A new instruction lands in the empty slot with the lowest index. Removal is decided only by age, so the slot position of an entry does not affect the order in which entries leave. The slot count, the payload width and the age width are parameters. A parameter also chooses how the oldest entry is found: a linear scan or a balanced comparison tree.

Top module: `age_slot_reg`

## Requirements
- R1: After reset every slot is empty: `push_ready` is 1 and `pop_valid` is 0.
- R2: `push_ready` is 1 exactly when at least one slot is empty. It reflects the state before any push or pop of the current cycle.
- R3: `pop_valid` is 1 exactly when at least one slot is occupied.
- R4: An accepted push (`push_valid` with `push_ready`) is stored at the next edge in the empty slot with the lowest index. `pop_slot` reports the index of the presented entry, with slot 0 first.
- R5: While `pop_valid` is 1, `pop_data`, `pop_age` and `pop_slot` describe the occupied slot with the smallest age. Ages are compared as unsigned `AGE_W`-bit numbers and are assumed unique.
- R6: `pop_req` while `pop_valid` is 1 empties the presented slot at the next edge.
- R7: `push_valid` while `push_ready` is 0 raises `push_err` in the same cycle. The push is discarded and leaves every slot unchanged.
- R8: A push and a pop in the same cycle both take effect. The entry popped is chosen from the contents before the push.
- R9: `pop_req` while `pop_valid` is 0 changes no state. While `pop_valid` is 0, `pop_data`, `pop_age` and `pop_slot` are all zero.
- R10: `SLOTS` defaults to 1 and must be at least 1. `DATA_W` and `AGE_W` must be at least 1. Elaboration rejects other values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer offers an instruction |
| push_data | input | DATA_W | Instruction payload |
| push_age | input | AGE_W | Age identifier of the instruction |
| push_ready | output | 1 | At least one slot is empty |
| push_err | output | 1 | Push attempted while no slot is empty |
| pop_req | input | 1 | Consumer removes the presented entry |
| pop_valid | output | 1 | At least one slot is occupied |
| pop_data | output | DATA_W | Payload of the oldest entry |
| pop_age | output | AGE_W | Age of the oldest entry |
| pop_slot | output | IDX_W | Slot index of the oldest entry |

## Verification
A directed part fills the pool with ages in scrambled order. This separates age-based removal from slot-position order and from arrival order. Pushes into the full pool, pops from the empty pool, and combined push and pop in one cycle, both when full and when partly filled, check the corner rules. Ages near the top of the 32-bit range against small ages catch a signed comparison. A long random stream of pushes and pops is compared every cycle with a queue model held in the bench. It uses unique ages built from an odd multiplier, on a five-slot build so that the comparison tree needs padding leaves.

// File: rtl/age_slot_pkg.sv
package age_slot_pkg;

   // Strategy used to locate the oldest occupied slot
   typedef enum logic [0:0] {
      PICK_SCAN = 1'b0,   // linear walk over the slots
      PICK_TREE = 1'b1    // balanced tree of pairwise comparisons
   } pick_style_e;

   // Width of a slot index; never below one bit
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/age_slot_free_pick.sv
// Finds the lowest-index empty slot
module age_slot_free_pick #(
   parameter int SLOTS = 1,
   parameter int IDX_W = 1
) (
   input  logic [SLOTS-1:0] occ,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx
);

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (!occ[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/age_slot_old_pick.sv
// Finds the occupied slot with the smallest age
module age_slot_old_pick
   import age_slot_pkg::*;
#(
   parameter int          SLOTS = 1,
   parameter int          AGE_W = 32,
   parameter int          IDX_W = 1,
   parameter pick_style_e PICK  = PICK_TREE
) (
   input  logic [SLOTS-1:0] occ,
   input  logic [AGE_W-1:0] ages [SLOTS],
   output logic             found,
   output logic [IDX_W-1:0] old_idx
);

   generate
      if (PICK == PICK_SCAN) begin : g_scan
         always_comb begin
            logic [AGE_W-1:0] best;
            found   = 1'b0;
            old_idx = '0;
            best    = '0;
            for (int i = 0; i < SLOTS; i++) begin
               if (occ[i] && (!found || ages[i] < best)) begin
                  found   = 1'b1;
                  best    = ages[i];
                  old_idx = IDX_W'(i);
               end
            end
         end
      end else begin : g_tree
         localparam int LEAVES = 1 << IDX_W;
         localparam int NODES  = 2 * LEAVES - 1;

         logic [NODES-1:0] nv;
         logic [AGE_W-1:0] na [NODES];
         logic [IDX_W-1:0] ni [NODES];

         for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
            if (l < SLOTS) begin : g_real
               assign nv[LEAVES-1+l] = occ[l];
               assign na[LEAVES-1+l] = ages[l];
            end else begin : g_pad
               assign nv[LEAVES-1+l] = 1'b0;
               assign na[LEAVES-1+l] = '0;
            end
            assign ni[LEAVES-1+l] = IDX_W'(l);
         end

         for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
            logic take_left;
            assign take_left = nv[2*n+1] &&
                               (!nv[2*n+2] || (na[2*n+1] < na[2*n+2]));
            assign nv[n] = nv[2*n+1] | nv[2*n+2];
            assign na[n] = take_left ? na[2*n+1] : na[2*n+2];
            assign ni[n] = take_left ? ni[2*n+1] : ni[2*n+2];
         end

         assign found   = nv[0];
         assign old_idx = ni[0];
      end
   endgenerate

endmodule

// File: rtl/age_slot_store.sv
// Slot storage: occupied bits, payloads and ages
module age_slot_store #(
   parameter int SLOTS  = 1,
   parameter int DATA_W = 16,
   parameter int AGE_W  = 32,
   parameter int IDX_W  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AGE_W-1:0] wr_age,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [SLOTS-1:0] occ,
   output logic [DATA_W-1:0] data [SLOTS],
   output logic [AGE_W-1:0] ages [SLOTS]
);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit_wr;
      logic hit_rd;
      assign hit_wr = wr_en && (wr_idx == IDX_W'(s));
      assign hit_rd = rd_en && (rd_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ[s]  <= 1'b0;
            data[s] <= '0;
            ages[s] <= '0;
         end else begin
            if (hit_rd) occ[s] <= 1'b0;
            if (hit_wr) begin
               occ[s]  <= 1'b1;
               data[s] <= wr_data;
               ages[s] <= wr_age;
            end
         end
      end
   end

endmodule

// File: rtl/age_slot_reg.sv
module age_slot_reg
   import age_slot_pkg::*;
#(
   parameter int          SLOTS  = 1,
   parameter int          DATA_W = 16,
   parameter int          AGE_W  = 32,
   parameter pick_style_e PICK   = PICK_TREE,
   localparam int         IDX_W  = idx_width(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic [AGE_W-1:0]  push_age,
   output logic              push_ready,
   output logic              push_err,
   input  logic              pop_req,
   output logic              pop_valid,
   output logic [DATA_W-1:0] pop_data,
   output logic [AGE_W-1:0]  pop_age,
   output logic [IDX_W-1:0]  pop_slot
);

   // Elaboration-time parameter checks (R10)
   if (SLOTS < 1)  begin : g_bad_slots $error("SLOTS must be at least 1"); end
   if (DATA_W < 1) begin : g_bad_data  $error("DATA_W must be at least 1"); end
   if (AGE_W < 1)  begin : g_bad_age   $error("AGE_W must be at least 1"); end

   logic [SLOTS-1:0]  occ;
   logic [DATA_W-1:0] data [SLOTS];
   logic [AGE_W-1:0]  ages [SLOTS];
   logic              any_free;
   logic [IDX_W-1:0]  free_idx;
   logic              found;
   logic [IDX_W-1:0]  old_idx;
   logic              push_fire;
   logic              pop_fire;

   age_slot_free_pick #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_free (
      .occ      (occ),
      .any_free (any_free),
      .free_idx (free_idx)
   );

   age_slot_old_pick #(.SLOTS(SLOTS), .AGE_W(AGE_W), .IDX_W(IDX_W), .PICK(PICK)) u_old (
      .occ     (occ),
      .ages    (ages),
      .found   (found),
      .old_idx (old_idx)
   );

   assign push_fire = push_valid && any_free;
   assign pop_fire  = pop_req && found;

   age_slot_store #(.SLOTS(SLOTS), .DATA_W(DATA_W), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_fire),
      .wr_idx  (free_idx),
      .wr_data (push_data),
      .wr_age  (push_age),
      .rd_en   (pop_fire),
      .rd_idx  (old_idx),
      .occ     (occ),
      .data    (data),
      .ages    (ages)
   );

   assign push_ready = any_free;
   assign push_err   = push_valid && !any_free;
   assign pop_valid  = found;
   assign pop_data   = found ? data[old_idx] : '0;
   assign pop_age    = found ? ages[old_idx] : '0;
   assign pop_slot   = found ? old_idx : '0;

endmodule

// File: rtl/age_slot_reg_chk.sv
module age_slot_reg_chk #(
   parameter int SLOTS = 1,
   parameter int IDX_W = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_valid,
   input logic             push_ready,
   input logic             push_err,
   input logic             pop_req,
   input logic             pop_valid,
   input logic [IDX_W-1:0] pop_slot,
   input logic [SLOTS-1:0] occ
);

   // R2
   free_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_ready == !(&occ));

   // R3
   occ_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid == (|occ));

   // R7
   full_push_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !push_ready) |-> push_err);

   // R7
   full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !push_ready && !pop_req) |=> $stable(occ));

   // R6
   pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid && pop_req && !push_valid) |=>
         ($countones(occ) == $past($countones(occ)) - 1));

   // R9
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop_valid && pop_req && !push_valid) |=> (occ == '0));

   // R4
   first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && occ == '0 && !pop_req) |=> (occ[0] && $countones(occ) == 1));

   // R9
   idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_valid |-> (pop_slot == '0));

endmodule

bind age_slot_reg age_slot_reg_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_valid (push_valid),
   .push_ready (push_ready),
   .push_err   (push_err),
   .pop_req    (pop_req),
   .pop_valid  (pop_valid),
   .pop_slot   (pop_slot),
   .occ        (occ)
);

// File: tb/tb_age_slot_reg.sv
`timescale 1ns/1ps
module tb_age_slot_reg;
   import age_slot_pkg::*;

   localparam int SLOTS  = 5;
   localparam int DATA_W = 16;
   localparam int AGE_W  = 32;
   localparam int IDX_W  = idx_width(SLOTS);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              push_valid = 1'b0;
   logic [DATA_W-1:0] push_data = '0;
   logic [AGE_W-1:0]  push_age = '0;
   logic              push_ready, push_err;
   logic              pop_req = 1'b0;
   logic              pop_valid;
   logic [DATA_W-1:0] pop_data;
   logic [AGE_W-1:0]  pop_age;
   logic [IDX_W-1:0]  pop_slot;

   int checks = 0;
   int errors = 0;

   // Reference model: one queue entry per occupied slot
   bit [DATA_W-1:0] m_data [$];
   bit [AGE_W-1:0]  m_age  [$];
   int              m_slot [$];

   always #4 clk = ~clk;   // 125 MHz

   age_slot_reg #(.SLOTS(SLOTS), .DATA_W(DATA_W), .AGE_W(AGE_W), .PICK(PICK_TREE)) dut (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_data(push_data), .push_age(push_age),
      .push_ready(push_ready), .push_err(push_err),
      .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
      .pop_age(pop_age), .pop_slot(pop_slot)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int low_free();
      for (int s = 0; s < SLOTS; s++) begin
         bit used = 0;
         foreach (m_slot[k]) if (m_slot[k] == s) used = 1;
         if (!used) return s;
      end
      return -1;
   endfunction

   function automatic int oldest();
      int best = -1;
      foreach (m_age[k]) if (best < 0 || m_age[k] < m_age[best]) best = k;
      return best;
   endfunction

   // Drive one cycle, compare outputs, then advance the model across the edge
   task automatic step(input bit pv, input bit [DATA_W-1:0] pd, input bit [AGE_W-1:0] pa,
                       input bit pr, input string req);
      int o, f;
      push_valid = pv; push_data = pd; push_age = pa; pop_req = pr;
      #1;
      o = oldest();
      f = low_free();
      chk({req, "/R2"}, "push_ready", push_ready, f >= 0);
      chk({req, "/R3"}, "pop_valid", pop_valid, o >= 0);
      chk({req, "/R7"}, "push_err", push_err, pv && f < 0);
      if (o >= 0) begin
         chk({req, "/R5"}, "pop_age", pop_age, m_age[o]);
         chk({req, "/R5"}, "pop_data", pop_data, m_data[o]);
         chk({req, "/R4"}, "pop_slot", pop_slot, m_slot[o]);
      end else begin
         chk({req, "/R9"}, "idle outputs", {pop_data, pop_age, pop_slot}, 0);
      end
      @(posedge clk);
      if (pr && o >= 0) begin
         m_data.delete(o); m_age.delete(o); m_slot.delete(o);
      end
      if (pv && f >= 0) begin
         m_data.push_back(pd); m_age.push_back(pa); m_slot.push_back(f);
      end
      #1;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: empty after reset
      chk("R1", "push_ready", push_ready, 1);
      chk("R1", "pop_valid", pop_valid, 0);

      // R9: pop on empty changes nothing
      step(0, 0, 0, 1, "R9");
      step(0, 0, 0, 0, "R9");

      // R4/R5: scrambled ages into slots 0..4
      step(1, 16'hA000, 32'd30, 0, "R4");
      step(1, 16'hA001, 32'd10, 0, "R4");
      step(1, 16'hA002, 32'd20, 0, "R4");
      step(1, 16'hA003, 32'd40, 0, "R4");
      step(1, 16'hA004, 32'd25, 0, "R4");
      // R7: push while full is flagged and dropped
      step(1, 16'hBAD0, 32'd1, 0, "R7");
      // R8: full pool, push and pop together; push rejected, pop of age 10 done
      step(1, 16'hBAD1, 32'd2, 1, "R8");
      // R8: one free slot, push older than everything while popping age 20
      step(1, 16'hA005, 32'd5, 1, "R8");
      step(0, 0, 0, 0, "R5");
      // R6: drain everything in age order
      for (int i = 0; i < 5; i++) step(0, 0, 0, 1, "R6");
      step(0, 0, 0, 1, "R9");

      // R5: unsigned compare at the top of the range
      step(1, 16'hC000, 32'hFFFF_FFF0, 0, "R5");
      step(1, 16'hC001, 32'h0000_0005, 0, "R5");
      step(1, 16'hC002, 32'h8000_0000, 0, "R5");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R5");

      // Random stream with unique ages
      for (int k = 1; k <= 3000; k++) begin
         bit [AGE_W-1:0] a;
         a = AGE_W'(k) * 32'h9E37_79B1;
         step(($urandom % 100) < 55, DATA_W'($urandom), a, ($urandom % 100) < 45, "R8");
      end

      // R1: reset in the middle clears all slots
      step(1, 16'hD000, 32'd7, 0, "R4");
      rst_n = 1'b0;
      @(posedge clk); #1;
      rst_n = 1'b1;
      m_data.delete(); m_age.delete(); m_slot.delete();
      chk("R1", "push_ready after reset", push_ready, 1);
      chk("R1", "pop_valid after reset", pop_valid, 0);
      step(0, 0, 0, 0, "R1");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule